// File: doc/BRIEF.md
# Two-Port Interleaved Halfword-Bank Data Memory

This block is the local data store for a core with two independent load/store buses, called port A and port B. The storage is eight single-ported banks, each 16 bits wide. They form two groups of four banks. Consecutive halfword addresses rotate through the four banks of a group, and the next four halfwords move on to the other group. Each port may issue one access per cycle: a byte, halfword or word, read or write. A word spans the two banks of an adjacent even/odd pair. When the two ports touch different banks, both accesses complete in the same cycle. When they share a bank, port A wins and port B is held off for that cycle.

Each bank row holds two bytes that can be written on their own, so byte stores leave the neighbouring byte intact. Read data is registered. It appears with the port's ready flag one cycle after the access is accepted. The number of rows per bank is a parameter. The full-size configuration uses 2048 rows per bank, which gives 32 KB. The default is smaller.

Top module: `ilv_dmem`

## Requirements
- R1: While reset is held and in the first cycle after it, `a_ready`, `b_ready` and `b_stall` are low when no request is present.
- R2: A byte address selects its bank with bits [3:1], and bit 3 picks one of the two four-bank groups. The row comes from bits [AW-1:4]. Two accesses in the same bank but different rows still collide. Accesses in different groups never collide.
- R3: When both ports request and their bank sets intersect, `b_stall` is high in that same cycle. Port B's access is not performed: a stalled write leaves memory unchanged.
- R4: When the bank sets of the two ports are disjoint, `b_stall` stays low and both ports see ready one cycle later.
- R5: Port A is never held off. Every cycle with `a_req` high is followed by `a_ready` high.
- R6: Read data is valid in the cycle ready is high. A byte read returns the byte in bits [7:0], and a halfword read returns it in bits [15:0], with the upper bits zero.
- R7: A byte write changes only the byte at its address. The other byte of the same halfword keeps its value.
- R8: A word uses the even bank of a pair for bits [15:0] and the odd bank for bits [31:16], in little-endian byte order. A word written and then read back is unchanged.
- R9: A port B request that is held steady after a stall is accepted in the first cycle with no collision, and it returns correct data.
- R10: Size code 00 means byte, 01 means halfword, and 10 or 11 means word. For halfword and word accesses, address bits below the access size are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Port A access request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_size | input | 2 | Port A size: 00 byte, 01 half, 1x word |
| a_addr | input | AW | Port A byte address |
| a_wdata | input | 32 | Port A store data, right-aligned |
| a_rdata | output | 32 | Port A load data, valid with a_ready |
| a_ready | output | 1 | Port A access completed last cycle |
| b_req | input | 1 | Port B access request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_size | input | 2 | Port B size: 00 byte, 01 half, 1x word |
| b_addr | input | AW | Port B byte address |
| b_wdata | input | 32 | Port B store data, right-aligned |
| b_rdata | output | 32 | Port B load data, valid with b_ready |
| b_ready | output | 1 | Port B access completed last cycle |
| b_stall | output | 1 | Port B collides with port A this cycle and is not served |

## Verification
The bench targets collisions that only part of a word causes. One example is a halfword on the odd bank of a pair while the other port makes a word access to that pair; a design that compared only starting banks would let both through and corrupt a bank. It also pairs same-bank, different-row accesses and cross-group accesses, which catches bank decoding that leaks group or row bits. A stalled store is followed by a read of its target, so a design that performed B's write anyway would show the new value. Byte stores followed by halfword loads show whether a design wrote the whole row, and unaligned halfword and word addresses show whether it failed to align them.

// File: rtl/ilv_dmem.sv
module ilv_dmem #(
  parameter int ROWS = 256,
  localparam int RW = $clog2(ROWS),
  localparam int AW = RW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_req,
  input  logic          a_we,
  input  logic [1:0]    a_size,
  input  logic [AW-1:0] a_addr,
  input  logic [31:0]   a_wdata,
  output logic [31:0]   a_rdata,
  output logic          a_ready,
  input  logic          b_req,
  input  logic          b_we,
  input  logic [1:0]    b_size,
  input  logic [AW-1:0] b_addr,
  input  logic [31:0]   b_wdata,
  output logic [31:0]   b_rdata,
  output logic          b_ready,
  output logic          b_stall
);
  localparam int NB = 8;

  function automatic logic [NB-1:0] bank_set(input logic [1:0] sz, input logic [2:0] bk);
    if (sz[1]) return 8'b11 << {bk[2:1], 1'b0};
    return 8'b1 << bk;
  endfunction

  function automatic logic [31:0] merge(input logic [16*NB-1:0] q, input logic [1:0] sz,
                                        input logic [2:0] bk, input logic lo);
    logic [6:0]  base;
    logic [15:0] hw;
    base = {bk[2:1], 1'b0, 4'b0};
    hw   = q[{bk, 4'b0} +: 16];
    if (sz[1]) return {q[base + 7'd16 +: 16], q[base +: 16]};
    if (sz[0]) return {16'h0, hw};
    return {24'h0, lo ? hw[15:8] : hw[7:0]};
  endfunction

  logic [NB-1:0] a_use, b_use, b_go_set;
  logic          collide, b_go;
  logic [16*NB-1:0] bq;

  assign a_use    = a_req ? bank_set(a_size, a_addr[3:1]) : '0;
  assign b_use    = b_req ? bank_set(b_size, b_addr[3:1]) : '0;
  assign collide  = |(a_use & b_use);
  assign b_go     = b_req & ~collide;
  assign b_stall  = b_req & collide;
  assign b_go_set = b_go ? b_use : '0;

  for (genvar k = 0; k < NB; k++) begin : g_bank
    logic [15:0]   mem [ROWS];
    logic [15:0]   q;
    logic          pick_b, en, we;
    logic [1:0]    sz, strb;
    logic [AW-1:0] ad;
    logic [31:0]   wd;
    logic [15:0]  din;

    assign pick_b = ~a_use[k];
    assign en     = a_use[k] | b_go_set[k];
    assign we     = pick_b ? b_we : a_we;
    assign sz     = pick_b ? b_size : a_size;
    assign ad     = pick_b ? b_addr : a_addr;
    assign wd     = pick_b ? b_wdata : a_wdata;
    assign din    = sz[1] ? ((k % 2 == 1) ? wd[31:16] : wd[15:0])
                  : sz[0] ? wd[15:0] : {wd[7:0], wd[7:0]};
    assign strb   = (sz == 2'b00) ? (ad[0] ? 2'b10 : 2'b01) : 2'b11;

    always_ff @(posedge clk) begin
      if (en) begin
        if (we && strb[0]) mem[ad[AW-1:4]][7:0]  <= din[7:0];
        if (we && strb[1]) mem[ad[AW-1:4]][15:8] <= din[15:8];
        q <= mem[ad[AW-1:4]];
      end
    end

    assign bq[16*k +: 16] = q;
  end

  logic [1:0] a_sz_q, b_sz_q;
  logic [2:0] a_bk_q, b_bk_q;
  logic       a_lo_q, b_lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_ready <= 1'b0;
      b_ready <= 1'b0;
    end else begin
      a_ready <= a_req;
      b_ready <= b_go;
    end
    a_sz_q <= a_size;
    a_bk_q <= a_addr[3:1];
    a_lo_q <= a_addr[0];
    b_sz_q <= b_size;
    b_bk_q <= b_addr[3:1];
    b_lo_q <= b_addr[0];
  end

  assign a_rdata = merge(bq, a_sz_q, a_bk_q, a_lo_q);
  assign b_rdata = merge(bq, b_sz_q, b_bk_q, b_lo_q);
endmodule

module ilv_dmem_chk #(parameter int AW = 12) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_req,
  input logic [1:0]    a_size,
  input logic [AW-1:0] a_addr,
  input logic          a_ready,
  input logic          b_req,
  input logic [1:0]    b_size,
  input logic [AW-1:0] b_addr,
  input logic          b_ready,
  input logic          b_stall
);
  logic [2:0] a_first, a_last, b_first, b_last;
  logic       overlap;

  assign a_first = a_size[1] ? {a_addr[3:2], 1'b0} : a_addr[3:1];
  assign a_last  = a_size[1] ? {a_addr[3:2], 1'b1} : a_addr[3:1];
  assign b_first = b_size[1] ? {b_addr[3:2], 1'b0} : b_addr[3:1];
  assign b_last  = b_size[1] ? {b_addr[3:2], 1'b1} : b_addr[3:1];
  assign overlap = (a_first == b_first) || (a_first == b_last) ||
                   (a_last == b_first)  || (a_last == b_last);

  a_r3_collide_stalls_b: assert property (@(posedge clk) disable iff (!rst_n)
    (a_req && b_req && overlap) |-> b_stall);
  a_r4_disjoint_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (b_req && !(a_req && overlap)) |-> !b_stall);
  a_r4_b_ready_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    (b_req && !b_stall) |=> b_ready);
  a_r5_a_always_served: assert property (@(posedge clk) disable iff (!rst_n)
    a_req |=> a_ready);
  a_r9_stall_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    b_stall |=> !b_ready);
  a_r1_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !b_req |-> !b_stall);
endmodule

bind ilv_dmem ilv_dmem_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_req(a_req), .a_size(a_size), .a_addr(a_addr), .a_ready(a_ready),
  .b_req(b_req), .b_size(b_size), .b_addr(b_addr), .b_ready(b_ready),
  .b_stall(b_stall)
);

// File: tb/sim_ilv_dmem.sv
module sim_ilv_dmem;
  localparam int AW = 12;

  logic clk = 0, rst_n = 0;
  logic a_req = 0, a_we = 0, b_req = 0, b_we = 0;
  logic [1:0] a_size = 0, b_size = 0;
  logic [AW-1:0] a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic a_ready, b_ready, b_stall;

  ilv_dmem u0 (.*);

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [7:0] mm [0:255];
  logic [33:0] qa[$], qb[$];
  string ta[$], tb[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ba(input logic [AW-1:0] ad);
    return ad[7:0];
  endfunction

  function automatic logic [31:0] mrd(input logic [AW-1:0] ad, input logic [1:0] sz);
    logic [7:0] x;
    x = ba(ad);
    if (sz[1]) begin
      x = x & 8'hFC;
      return {mm[x+3], mm[x+2], mm[x+1], mm[x]};
    end
    if (sz[0]) begin
      x = x & 8'hFE;
      return {16'h0, mm[x+1], mm[x]};
    end
    return {24'h0, mm[x]};
  endfunction

  task automatic mwr(input logic [AW-1:0] ad, input logic [1:0] sz, input logic [31:0] d);
    logic [7:0] x;
    x = ba(ad);
    if (sz[1]) begin
      x = x & 8'hFC;
      mm[x] = d[7:0]; mm[x+1] = d[15:8]; mm[x+2] = d[23:16]; mm[x+3] = d[31:24];
    end else if (sz[0]) begin
      x = x & 8'hFE;
      mm[x] = d[7:0]; mm[x+1] = d[15:8];
    end else mm[x] = d[7:0];
  endtask

  function automatic bit banks_meet(input logic [AW-1:0] pa, input logic [1:0] sa,
                                    input logic [AW-1:0] pb, input logic [1:0] sb);
    int ha, hb, na, nb;
    ha = sa[1] ? (int'(pa) / 4) * 2 : int'(pa) / 2;
    hb = sb[1] ? (int'(pb) / 4) * 2 : int'(pb) / 2;
    na = sa[1] ? 2 : 1;
    nb = sb[1] ? 2 : 1;
    for (int i = 0; i < na; i++)
      for (int j = 0; j < nb; j++)
        if ((ha + i) % 8 == (hb + j) % 8) return 1;
    return 0;
  endfunction

  task automatic step(input logic ar, input logic aw, input logic [1:0] as,
                      input logic [AW-1:0] aa, input logic [31:0] ad,
                      input logic br, input logic bw, input logic [1:0] bs,
                      input logic [AW-1:0] bb, input logic [31:0] bd, input string tag);
    bit hit;
    logic [31:0] ea, eb;
    @(negedge clk);
    a_req = ar; a_we = aw; a_size = as; a_addr = aa; a_wdata = ad;
    b_req = br; b_we = bw; b_size = bs; b_addr = bb; b_wdata = bd;
    #1;
    hit = ar && br && banks_meet(aa, as, bb, bs);
    chk(b_stall === (br && hit), hit ? "R3" : tag, "b_stall", {31'h0, b_stall}, {31'h0, br && hit});
    ea = ar ? mrd(aa, as) : 32'h0;
    eb = br ? mrd(bb, bs) : 32'h0;
    qa.push_back({ar, ar && !aw, ea}); ta.push_back(tag);
    qb.push_back({br && !hit, br && !hit && !bw, eb}); tb.push_back(hit ? "R3" : tag);
    if (ar && aw) mwr(aa, as, ad);
    if (br && !hit && bw) mwr(bb, bs, bd);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
  endtask

  always @(posedge clk) begin
    logic [33:0] e;
    string t;
    #3;
    if (qa.size() > 0) begin
      e = qa.pop_front(); t = ta.pop_front();
      chk(a_ready === e[33], e[33] ? "R5" : t, "a_ready", {31'h0, a_ready}, {31'h0, e[33]});
      if (e[33] && e[32]) chk(a_rdata === e[31:0], t, "a_rdata", a_rdata, e[31:0]);
    end
    if (qb.size() > 0) begin
      e = qb.pop_front(); t = tb.pop_front();
      chk(b_ready === e[33], t, "b_ready", {31'h0, b_ready}, {31'h0, e[33]});
      if (e[33] && e[32]) chk(b_rdata === e[31:0], t, "b_rdata", b_rdata, e[31:0]);
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    chk(a_ready === 0 && b_ready === 0 && b_stall === 0, "R1", "reset outputs",
        {29'h0, a_ready, b_ready, b_stall}, 32'h0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #3;
    chk(a_ready === 0 && b_ready === 0 && b_stall === 0, "R1", "after reset",
        {29'h0, a_ready, b_ready, b_stall}, 32'h0);

    // fill 256 bytes with words, A on banks {0,1}/{4,5}, B on {2,3}/{6,7}
    for (int i = 0; i < 32; i++)
      step(1, 1, 2'b10, AW'(i * 8), $urandom, 1, 1, 2'b10, AW'(i * 8 + 4), $urandom, "R8");

    // R8: word read back on both ports, no collision
    step(1, 0, 2'b10, 12'h000, 0, 1, 0, 2'b10, 12'h00C, 0, "R8");
    // R6: byte and halfword zero extension
    step(1, 0, 2'b00, 12'h003, 0, 1, 0, 2'b01, 12'h016, 0, "R6");
    step(1, 0, 2'b00, 12'h041, 0, 1, 0, 2'b01, 12'h05C, 0, "R6");
    // R8: halves of a word land in even and odd banks
    step(1, 0, 2'b01, 12'h024, 0, 1, 0, 2'b01, 12'h02A, 0, "R8");
    // R2: other group, no collision; same banks different row, collision
    step(1, 0, 2'b10, 12'h000, 0, 1, 0, 2'b10, 12'h008, 0, "R2");
    step(1, 0, 2'b10, 12'h000, 0, 1, 0, 2'b10, 12'h010, 0, "R2");
    step(1, 0, 2'b10, 12'h020, 0, 1, 0, 2'b10, 12'h030, 0, "R2");
    // R3: collided write by B is dropped, then read target
    step(1, 1, 2'b00, 12'h020, 32'h5A, 1, 1, 2'b01, 12'h040, 32'hBEEF, "R3");
    step(1, 0, 2'b01, 12'h040, 0, 0, 0, 0, 0, 0, "R3");
    // R3: partial overlap, half on odd bank of A's word pair
    step(1, 0, 2'b10, 12'h000, 0, 1, 0, 2'b01, 12'h012, 0, "R3");
    // R9: held B request served once A goes idle
    step(0, 0, 0, 0, 0, 1, 0, 2'b01, 12'h012, 0, "R9");
    step(1, 1, 2'b10, 12'h064, 32'hCAFE_F00D, 1, 1, 2'b00, 12'h067, 32'h77, "R9");
    step(1, 0, 2'b10, 12'h070, 0, 1, 1, 2'b00, 12'h067, 32'h77, "R9");
    step(1, 0, 2'b10, 12'h064, 0, 0, 0, 0, 0, 0, "R9");
    // R5: A served on every cycle of a repeated collision
    for (int i = 0; i < 3; i++)
      step(1, 0, 2'b01, AW'(12'h080 + i * 16), 0, 1, 1, 2'b01, 12'h090, 32'h1234, "R5");
    // R7: byte writes keep neighbour byte
    step(1, 1, 2'b00, 12'h035, 32'hAB, 1, 1, 2'b00, 12'h0C8, 32'hCD, "R7");
    step(1, 0, 2'b01, 12'h034, 0, 1, 0, 2'b01, 12'h0C8, 0, "R7");
    step(1, 1, 2'b00, 12'h034, 32'h11, 0, 0, 0, 0, 0, "R7");
    step(1, 0, 2'b10, 12'h034, 0, 0, 0, 0, 0, 0, "R7");
    // R10: unaligned half, size 11 as word, unaligned word
    step(1, 0, 2'b01, 12'h037, 0, 1, 0, 2'b11, 12'h01E, 0, "R10");
    step(1, 1, 2'b01, 12'h0A3, 32'h9876, 1, 1, 2'b11, 12'h0BD, 32'h0102_0304, "R10");
    step(1, 0, 2'b10, 12'h0A2, 0, 1, 0, 2'b10, 12'h0BC, 0, "R10");

    // mixed traffic
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 1), $urandom_range(0, 1), 2'($urandom), AW'($urandom_range(0, 255)),
           $urandom, $urandom_range(0, 1), $urandom_range(0, 1), 2'($urandom),
           AW'($urandom_range(0, 255)), $urandom, "R4");

    repeat (3) idle();
    @(posedge clk); #4;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule